// File: doc/BRIEF.md
# AT Command Frame Serializer

The serializer sends a fixed modem command of eleven 8-bit characters (for example `AT+CMGR=` followed by a three-character storage location) to a byte-wide UART transmitter. The whole command arrives as one 88-bit word on `cmd_i`. A message-arrival line from the modem side, which may be asynchronous to the clock, starts the sequence. The block passes it through a synchronizer, turns its rising edge into a single-cycle enable pulse and uses that pulse to capture the command word into a local frame register.

After the capture, the sequencer presents the captured characters one at a time, first character first. Each character comes with a one-cycle valid strobe. The block then waits for the transmitter's done indication before it presents the next character. When the transmitter reports the eleventh character as done, a one-cycle completion pulse follows and the block returns to idle. A message arrival that comes while a frame is still in progress is dropped. Nothing is queued.

Top module: `at_cmd_serializer`

## Requirements
- R1: While `rst_ni` is low, `tx_valid_o`, `frame_done_o`, `busy_o` and `en_pulse_o` are 0.
- R2: A rising edge on `msg_arrive_i` gives exactly one cycle of `en_pulse_o`. That cycle is the one that follows the second clock edge after the input is first sampled high. Holding the input high gives no further pulses.
- R3: The enable pulse accepted in idle captures `cmd_i`. Changes on `cmd_i` after the capture do not change the bytes of that frame.
- R4: Byte number i (i = 0 first, i = 10 last) presented on `tx_data_o` equals `cmd_i[8*(10-i)+7 : 8*(10-i)]` of the captured word. The most significant character goes first.
- R5: `tx_valid_o` is a one-cycle strobe. The first strobe comes in the cycle right after the accepted enable pulse. Each later strobe comes in the cycle right after the clock edge that samples `tx_done_i` high for the previous byte.
- R6: A `tx_done_i` that is high during a strobe cycle or while idle is ignored. The byte does not advance and no strobe follows.
- R7: `frame_done_o` is high for exactly one cycle, the cycle after the edge that samples `tx_done_i` for byte 10. `busy_o` is high from the first strobe through that cycle and low afterwards.
- R8: An enable pulse that occurs while `busy_o` is high, including the completion cycle, starts no frame and does not disturb the frame in progress.
- R9: Asserting `rst_ni` in the middle of a frame returns the block to idle at once. The next accepted arrival starts again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_arrive_i | input | 1 | Message-stored indication, may be asynchronous |
| cmd_i | input | 88 | Command word, eleven characters, first character in the top byte |
| tx_done_i | input | 1 | Transmitter has finished the current byte |
| en_pulse_o | output | 1 | One-cycle enable pulse from the rising edge of the arrival line |
| tx_data_o | output | 8 | Byte offered to the transmitter |
| tx_valid_o | output | 1 | One-cycle strobe that qualifies `tx_data_o` |
| busy_o | output | 1 | A frame is in progress |
| frame_done_o | output | 1 | One-cycle pulse after the last byte completes |

## Verification
Two events can coincide: an arrival edge can produce its enable pulse in the very cycle in which the completion pulse of the previous frame is raised. The bench provokes this by raising the arrival line exactly one cycle before it returns the eleventh done. In that cycle it requires `en_pulse_o` and `frame_done_o` to be high together. In the cycles that follow it requires `tx_valid_o` to stay low and `busy_o` to drop, so the pulse starts no new frame. A second test pulses the done input during a strobe cycle, where it must be dropped.

// File: rtl/at_ser_pkg.sv
package at_ser_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_FIN   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/at_ser_edge.sv
module at_ser_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pulse_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R2
  en_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/at_ser_frame.sv
module at_ser_frame #(
  parameter int unsigned NUM_BYTES = 11,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned FRAME_W  = NUM_BYTES * BYTE_W,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [BYTE_W-1:0]  byte_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic [FRAME_W-1:0] frame_q;
  logic [BYTE_W-1:0]  lanes [NUM_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= '0;
    else if (load_i) frame_q <= frame_i;
  end

  // lane 0 is the top character: sent first
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign lanes[g] = frame_q[(NUM_BYTES-1-g)*BYTE_W +: BYTE_W];
  end

  assign byte_o = (idx_i <= LAST_IDX) ? lanes[idx_i] : '0;

  // R3
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(frame_q));

endmodule

// File: rtl/at_ser_seq.sv
module at_ser_seq
  import at_ser_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 11,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tx_done_i,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             tx_valid_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_ISSUE;
          idx_q   <= '0;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (tx_done_i) begin
          if (idx_q == LAST_IDX) begin
            state_q <= S_FIN;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_ISSUE;
          end
        end
        S_FIN: begin
          state_q <= S_IDLE;
          idx_q   <= '0;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign load_o     = start_i && (state_q == S_IDLE);
  assign idx_o      = idx_q;
  assign tx_valid_o = (state_q == S_ISSUE);
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_FIN);

  // R5
  valid_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);

  // R6
  valid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_o) |-> ($past(load_o) || $past(tx_done_i)));

  // R7
  done_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(tx_done_i) && $past(idx_q) == LAST_IDX));

  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !(tx_valid_o && idx_q == '0));

endmodule

// File: rtl/at_cmd_serializer.sv
module at_cmd_serializer #(
  parameter int unsigned NUM_BYTES   = 11,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          msg_arrive_i,
  input  logic [NUM_BYTES*BYTE_W-1:0]   cmd_i,
  input  logic                          tx_done_i,
  output logic                          en_pulse_o,
  output logic [BYTE_W-1:0]             tx_data_o,
  output logic                          tx_valid_o,
  output logic                          busy_o,
  output logic                          frame_done_o
);

  localparam int unsigned IDX_W = $clog2(NUM_BYTES);

  logic             en_pulse;
  logic             load;
  logic [IDX_W-1:0] idx;

  at_ser_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(msg_arrive_i),
    .pulse_o(en_pulse)
  );

  at_ser_seq #(
    .NUM_BYTES(NUM_BYTES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (en_pulse),
    .tx_done_i (tx_done_i),
    .load_o    (load),
    .idx_o     (idx),
    .tx_valid_o(tx_valid_o),
    .busy_o    (busy_o),
    .done_o    (frame_done_o)
  );

  at_ser_frame #(
    .NUM_BYTES(NUM_BYTES),
    .BYTE_W   (BYTE_W)
  ) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .frame_i(cmd_i),
    .idx_i  (idx),
    .byte_o (tx_data_o)
  );

  assign en_pulse_o = en_pulse;

endmodule

// File: tb/at_cmd_serializer_tb.sv
module at_cmd_serializer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 11;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          msg = 1'b0;
  logic [87:0]   cmd = '0;
  logic          tx_done = 1'b0;
  logic          en_pulse, tx_valid, busy, fdone;
  logic [7:0]    tx_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  at_cmd_serializer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .msg_arrive_i(msg),
    .cmd_i       (cmd),
    .tx_done_i   (tx_done),
    .en_pulse_o  (en_pulse),
    .tx_data_o   (tx_data),
    .tx_valid_o  (tx_valid),
    .busy_o      (busy),
    .frame_done_o(fdone)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [87:0] make_cmd(input int pat);
    logic [87:0] c = '0;
    for (int b = 0; b < NB; b++)
      c[8*(10-b) +: 8] = 8'((b * (pat * 37 + 5) + pat * 11 + 1) & 8'hff);
    return c;
  endfunction

  task automatic run_frame(input logic [87:0] c, input int dly, input bit spur,
                           input bit coin, input int abort_at);
    msg = 1'b1;
    cmd = c;
    @(negedge clk); chk("R2 no pulse yet", 32'(en_pulse), 0);
    @(negedge clk); chk("R2 pulse", 32'(en_pulse), 1);
    chk("R5 no strobe with pulse", 32'(tx_valid), 0);
    @(negedge clk); chk("R2 single pulse", 32'(en_pulse), 0);
    cmd = ~c;  // R3: late change must not reach the frame
    for (int i = 0; i < NB; i++) begin
      if (i == abort_at) begin
        rst_ni = 1'b0;
        msg = 1'b0;
        #1;
        chk("R9 reset valid", 32'(tx_valid), 0);
        chk("R9 reset busy", 32'(busy), 0);
        @(negedge clk);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk);
        return;
      end
      chk("R4 byte", 32'(tx_data), 32'(c[8*(10-i) +: 8]));
      chk("R5 strobe", 32'(tx_valid), 1);
      chk("R7 no early done", 32'(fdone), 0);
      if (!coin && i == 3) msg = 1'b0;
      if (!coin && i == 5) msg = 1'b1;  // R8 arrival mid-frame
      if (coin && i == 0) msg = 1'b0;
      if (spur) tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      chk("R6 strobe low", 32'(tx_valid), 0);
      for (int w = 0; w < dly; w++) begin
        if (coin && i == NB-1 && w == dly-1) msg = 1'b1;
        @(negedge clk);
        chk("R6 waiting", 32'(tx_valid), 0);
      end
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
    end
    chk("R7 done pulse", 32'(fdone), 1);
    chk("R7 busy in done", 32'(busy), 1);
    chk("R7 no strobe", 32'(tx_valid), 0);
    if (coin) chk("R8 pulse with done", 32'(en_pulse), 1);
    @(negedge clk);
    chk("R7 done single", 32'(fdone), 0);
    chk("R7 busy drops", 32'(busy), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 no restart", 32'(tx_valid), 0);
      chk("R8 idle", 32'(busy), 0);
    end
    msg = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 valid", 32'(tx_valid), 0);
    chk("R1 done", 32'(fdone), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 pulse", 32'(en_pulse), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R6: done while idle
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    @(negedge clk);
    chk("R6 idle done", 32'(tx_valid), 0);
    chk("R6 idle busy", 32'(busy), 0);

    run_frame({"AT+CMGR=", "123"}, 1, 1'b0, 1'b0, -1);
    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 4; d++)
        for (int s = 0; s < 2; s++)
          run_frame(make_cmd(p), d, s[0], 1'b0, -1);
    run_frame(make_cmd(4), 1, 1'b0, 1'b1, -1);
    run_frame(make_cmd(5), 3, 1'b1, 1'b1, -1);
    run_frame(make_cmd(6), 2, 1'b0, 1'b0, 4);   // R9 abort
    run_frame(make_cmd(7), 0, 1'b0, 1'b0, -1);  // R9 restart at byte 0

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule